// File: doc/BRIEF.md
# Port Change Wakeup Interrupt Controller

This block watches a four-pin input port and turns level changes on it into a latched per-pin status, a port event flag that can interrupt the processor, and a one-cycle pulse that releases a hold-mode request. Each pin passes through a two-flop synchronizer first. A write-only enable mask decides which pins take part. Accepting the interrupt drops the event flag but leaves the per-pin status for software to read. The status is emptied only by an explicit clear, by rewriting the enable mask, or by reset.

Stop-mode wakeup is handled apart from this. A second write-only mask selects the pins whose falling edge requests an exit from stop mode. That request is formed combinationally from the synchronized levels and holds no state of its own.

Top module: `pcw_ctrl`

## Requirements
- R1: Each pin goes through two synchronizer flops. A change on an enabled pin n sets status bit n (status bit n belongs to pin n) on the third rising clock edge after the pin changes.
- R2: A change on a pin whose enable bit is 0 sets no status bit, no event flag and no hold-release pulse.
- R3: An enabled change sets the event flag on the same edge as its status bit. The interrupt request output is high exactly while the event flag and the interrupt-enable input are both high.
- R4: Asserting interrupt accept clears the event flag on the next edge and leaves the status unchanged. If an enabled change lands on that same edge, the event flag stays set.
- R5: The status-clear command empties the status on the next edge. A change landing on that same edge still sets its bit. The clear does not touch the event flag.
- R6: Writing the enable mask loads the new mask and empties the status on the same edge.
- R7: The hold-release output is a one-cycle pulse, shown in the cycle in which the status bit first appears, on any enabled change, whatever the interrupt enable is.
- R8: The stop-exit output is high for one cycle, starting after the second rising edge following a falling edge on a pin whose stop-select bit is 1. Rising edges and pins that are not selected do not raise it.
- R9: Synchronous reset empties both masks, the status and the event flag, so that no change can interrupt, release hold or exit stop until software sets the masks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Asynchronous port pin levels |
| en_wr_i | input | 1 | Load the enable mask from en_data_i; also clears status |
| en_data_i | input | 4 | New enable mask value |
| stw_wr_i | input | 1 | Load the stop-wakeup select from stw_data_i |
| stw_data_i | input | 4 | New stop-wakeup select value |
| stat_clr_i | input | 1 | Clear-status command |
| irq_ack_i | input | 1 | Interrupt accepted; clears the event flag |
| irq_en_i | input | 1 | Interrupt enable for the port event |
| status_o | output | 4 | Latched per-pin change status |
| event_o | output | 1 | Port event flag |
| irq_o | output | 1 | Interrupt request |
| hold_rel_o | output | 1 | One-cycle hold-release pulse |
| stop_exit_o | output | 1 | Stop-mode exit request |

## Verification
The hardest cases to reach from the ports are the same-edge collisions, where a clear command or an interrupt accept lands on exactly the edge on which a synchronized change registers. The bench counts the synchronizer latency from the pin edge, drives the pin at a falling clock edge, waits two rising edges, and then raises the command for exactly one cycle, so that both act on the third edge. A second status bit set beforehand shows that the clear did act while the new bit survived it.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    localparam int unsigned NPIN = 4;

    typedef logic [NPIN-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t lvl;
        pin_vec_t rise;
        pin_vec_t fall;
    } pin_evt_t;

    typedef struct packed {
        pin_vec_t status;
        logic     evt;
        logic     pulse;
    } stat_state_t;

    function automatic pin_evt_t classify(pin_vec_t now, pin_vec_t last);
        pin_evt_t e;
        e.lvl  = now;
        e.rise = now & ~last;
        e.fall = ~now & last;
        return e;
    endfunction
endpackage

// File: rtl/pcw_sync.sv
module pcw_sync
    import pcw_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pin_i,
    output pin_evt_t evt_o
);
    localparam int unsigned LAST = STAGES - 1;

    pin_vec_t chain [STAGES];
    pin_vec_t last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= chain[LAST];
    end

    assign evt_o = classify(chain[LAST], last_q);
endmodule

// File: rtl/pcw_cfg.sv
module pcw_cfg
    import pcw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  pin_vec_t data_i,
    output pin_vec_t mask_o
);
    always_ff @(posedge clk) begin
        if (rst)       mask_o <= '0;
        else if (wr_i) mask_o <= data_i;
    end
endmodule

// File: rtl/pcw_status.sv
module pcw_status
    import pcw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_vec_t    hit_i,
    input  logic        clr_i,
    input  logic        ack_i,
    output stat_state_t st_o
);
    stat_state_t st_q, st_d;
    logic        any_hit;

    assign any_hit = |hit_i;

    always_comb begin
        st_d        = st_q;
        st_d.status = (clr_i ? '0 : st_q.status) | hit_i;
        st_d.evt    = (ack_i ? 1'b0 : st_q.evt) | any_hit;
        st_d.pulse  = any_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/pcw_ctrl.sv
module pcw_ctrl
    import pcw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPIN-1:0] pin_i,
    input  logic           en_wr_i,
    input  logic [NPIN-1:0] en_data_i,
    input  logic           stw_wr_i,
    input  logic [NPIN-1:0] stw_data_i,
    input  logic           stat_clr_i,
    input  logic           irq_ack_i,
    input  logic           irq_en_i,
    output logic [NPIN-1:0] status_o,
    output logic           event_o,
    output logic           irq_o,
    output logic           hold_rel_o,
    output logic           stop_exit_o
);
    pin_evt_t    evt;
    pin_vec_t    en_mask;
    pin_vec_t    stw_mask;
    pin_vec_t    hit;
    stat_state_t st;

    pcw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_i),
        .evt_o (evt)
    );

    pcw_cfg u_en_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (en_wr_i),
        .data_i (en_data_i),
        .mask_o (en_mask)
    );

    pcw_cfg u_stw_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (stw_wr_i),
        .data_i (stw_data_i),
        .mask_o (stw_mask)
    );

    assign hit = (evt.rise | evt.fall) & en_mask;

    pcw_status u_status (
        .clk   (clk),
        .rst   (rst),
        .hit_i (hit),
        .clr_i (stat_clr_i | en_wr_i),
        .ack_i (irq_ack_i),
        .st_o  (st)
    );

    assign status_o    = st.status;
    assign event_o     = st.evt;
    assign hold_rel_o  = st.pulse;
    assign irq_o       = st.evt & irq_en_i;
    assign stop_exit_o = |(evt.fall & stw_mask);
endmodule

// File: rtl/pcw_ctrl_chk.sv
module pcw_ctrl_chk
    import pcw_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     en_wr_i,
    input logic     stat_clr_i,
    input logic     irq_ack_i,
    input logic     irq_en_i,
    input pin_vec_t status_o,
    input logic     event_o,
    input logic     irq_o,
    input logic     hold_rel_o,
    input logic     stop_exit_o,
    input pin_vec_t stw_mask
);
    AST_STATUS_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (!stat_clr_i && !en_wr_i) |=> ((status_o & $past(status_o)) == $past(status_o))); // R4

    AST_NEW_BIT_RAISES_EVENT: assert property (@(posedge clk) disable iff (rst)
        ((status_o & ~$past(status_o)) != '0) |-> event_o); // R3

    AST_HOLD_WITH_EVENT: assert property (@(posedge clk) disable iff (rst)
        hold_rel_o |-> event_o); // R7

    AST_ACK_DROPS_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq_ack_i |=> (!event_o || hold_rel_o)); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (event_o && irq_en_i)); // R3

    AST_STOP_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        stop_exit_o |-> (stw_mask != '0)); // R8
endmodule

bind pcw_ctrl pcw_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_wr_i     (en_wr_i),
    .stat_clr_i  (stat_clr_i),
    .irq_ack_i   (irq_ack_i),
    .irq_en_i    (irq_en_i),
    .status_o    (status_o),
    .event_o     (event_o),
    .irq_o       (irq_o),
    .hold_rel_o  (hold_rel_o),
    .stop_exit_o (stop_exit_o),
    .stw_mask    (stw_mask)
);

// File: tb/pcw_ctrl_test.sv
module pcw_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin = '0;
    logic       en_wr = 1'b0;
    logic [3:0] en_data = '0;
    logic       stw_wr = 1'b0;
    logic [3:0] stw_data = '0;
    logic       stat_clr = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_en = 1'b0;
    logic [3:0] status;
    logic       evt, irq, hold, stop_x;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcw_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .en_wr_i     (en_wr),
        .en_data_i   (en_data),
        .stw_wr_i    (stw_wr),
        .stw_data_i  (stw_data),
        .stat_clr_i  (stat_clr),
        .irq_ack_i   (irq_ack),
        .irq_en_i    (irq_en),
        .status_o    (status),
        .event_o     (evt),
        .irq_o       (irq),
        .hold_rel_o  (hold),
        .stop_exit_o (stop_x)
    );

    // mask, pins before, pins after, expected status
    localparam logic [15:0] VEC [4] = '{
        {4'b1111, 4'b0000, 4'b0101, 4'b0101},
        {4'b1011, 4'b0000, 4'b1111, 4'b1011},
        {4'b0110, 4'b1111, 4'b0011, 4'b0100},
        {4'b0001, 4'b1010, 4'b0100, 4'b0000}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_en(input logic [3:0] m);
        en_data = m; en_wr = 1'b1; irq_ack = 1'b1;
        step(1);
        en_wr = 1'b0; irq_ack = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R9 reset state
        check("R9 status after reset", {4'b0, status}, 8'h00);
        check("R9 event after reset", {7'b0, evt}, 8'h00);
        check("R9 outputs after reset", {5'b0, irq, hold, stop_x}, 8'h00);

        foreach (VEC[i]) begin
            pin = VEC[i][11:8];
            step(4);
            write_en(VEC[i][15:12]);
            pin = VEC[i][7:4];
            step(3);
            check("R1 R2 vector status", {4'b0, status}, {4'b0, VEC[i][3:0]});
            check("R3 vector event", {7'b0, evt}, {7'b0, VEC[i][3:0] != 4'b0});
            check("R7 vector hold pulse", {7'b0, hold}, {7'b0, VEC[i][3:0] != 4'b0});
            step(1);
            check("R7 hold pulse ends", {7'b0, hold}, 8'h00);
        end

        // R3 / R7: interrupt gating, hold without irq enable
        write_en(4'b1111);
        pin = 4'b0101;
        step(3);
        check("R1 status bit0", {4'b0, status}, 8'h01);
        check("R7 hold with irq disabled", {7'b0, hold}, 8'h01);
        check("R3 irq gated off", {7'b0, irq}, 8'h00);
        irq_en = 1'b1;
        #1;
        check("R3 irq on with enable", {7'b0, irq}, 8'h01);

        // R4 accept
        @(negedge clk);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        check("R4 event cleared by accept", {7'b0, evt}, 8'h00);
        check("R4 status kept after accept", {4'b0, status}, 8'h01);
        check("R3 irq follows event", {7'b0, irq}, 8'h00);

        // R5 clear colliding with change
        pin = 4'b0111;
        step(2);
        stat_clr = 1'b1;
        step(1);
        stat_clr = 1'b0;
        check("R5 change wins over clear", {4'b0, status}, 8'h02);
        check("R5 event set", {7'b0, evt}, 8'h01);
        stat_clr = 1'b1;
        step(1);
        stat_clr = 1'b0;
        check("R5 clear empties status", {4'b0, status}, 8'h00);
        check("R5 clear leaves event", {7'b0, evt}, 8'h01);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;

        // R4 accept colliding with change
        pin = 4'b0110;
        step(2);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        check("R4 change wins over accept", {7'b0, evt}, 8'h01);
        check("R4 status bit0", {4'b0, status}, 8'h01);

        // R6 mask write clears status; R2 disabled pin
        write_en(4'b0010);
        check("R6 mask write clears status", {4'b0, status}, 8'h00);
        pin = 4'b0111;
        step(3);
        check("R2 disabled pin status", {4'b0, status}, 8'h00);
        check("R2 disabled pin hold", {7'b0, hold}, 8'h00);
        pin = 4'b0101;
        step(3);
        check("R6 new mask in effect", {4'b0, status}, 8'h02);

        // R8 stop exit
        stw_data = 4'b0100; stw_wr = 1'b1;
        step(1);
        stw_wr = 1'b0;
        pin = 4'b0001;
        step(2);
        check("R8 falling selected pin", {7'b0, stop_x}, 8'h01);
        step(1);
        check("R8 one cycle only", {7'b0, stop_x}, 8'h00);
        pin = 4'b0101;
        step(2);
        check("R8 rising edge ignored", {7'b0, stop_x}, 8'h00);
        pin = 4'b0100;
        step(2);
        check("R8 unselected pin ignored", {7'b0, stop_x}, 8'h00);

        // R9 reset clears masks
        pin = 4'b0000;
        step(4);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        check("R9 status cleared", {4'b0, status}, 8'h00);
        check("R9 event cleared", {7'b0, evt}, 8'h00);
        pin = 4'b0110;
        step(4);
        pin = 4'b0000;
        step(2);
        check("R9 stop select cleared", {7'b0, stop_x}, 8'h00);
        step(1);
        check("R9 enable mask cleared", {4'b0, status, 3'b0, evt}, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(20 * 200000);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule